// File: doc/BRIEF.md
# Cascadable Two-Bit ALU Slice Array

This block is a datapath built from identical two-bit processing slices placed side by side. A parameter sets the number of slices, and every slice takes the same 7-bit function code, so the whole row behaves as one W-bit unit, where W is twice the slice count. Each slice holds its two bits of twelve working registers, its two bits of a memory address register, and a small ALU. The twelve working registers are ten general scratch registers, a temporary register and the accumulator.

Operands come from the selected register, the accumulator, and the M and I input buses. The K input is a per-cycle mask that gates the second ALU operand. The carry links run from the lowest slice to the highest. The shift links run from the highest slice to the lowest. Results are stored at the rising clock edge. The A output always shows the address register and the D output always shows the accumulator.

The block has no state machine. Its only state is the register file and the address register. Each cycle it performs one operation, chosen by the function group and the register select.

Top module: `bitslice_array`

## Requirements
- R1: While `rst_n` is low, every working register and the address register are cleared to zero, so `a_bus` and `d_bus` read 0.
- R2: `func[6:4]` selects the group and `func[3:0]` selects the register. Select values 0 to 9 are the scratch registers, 10 is the temporary register and 11 is the accumulator. With a select of 12 to 15, no storage changes, `co` equals `ci` and `ro` is 0.
- R3: The second ALU operand is the mask `k_bus` ANDed bitwise with the B source. The B source is the accumulator in every group except group 1, where it is all ones.
- R4: Group 0 computes Rn + (AC & K) + CI and writes the result to both Rn and the accumulator. `co` is the carry out of the top bit.
- R5: Group 1 loads the address register with Rn OR K and writes Rn + K + CI back to Rn. `co` is the carry out of the top bit. With K all zeros this copies Rn to the address register. With K all ones it sets the address register to all ones and decrements Rn, plus CI.
- R6: Groups 2, 3 and 4 write Rn AND (AC & K), Rn OR (AC & K) and Rn XNOR (AC & K) to Rn. `co` is CI ORed with every bit of the result.
- R7: Group 5 writes M XNOR (AC & K) to Rn, with `co` formed as in R6. With K all zeros this stores the complement of M.
- R8: Group 6 writes I + (AC & K) + CI to Rn. `co` is the carry out of the top bit.
- R9: Group 7 shifts Rn right by one. `li` enters the top bit, `ro` shows the old bit 0, and `co` equals `ci`. In every other group `ro` is 0.
- R10: `a_bus` shows the address register and `d_bus` shows the accumulator, both updating after the rising edge. Only group 1 changes the address register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func | input | 7 | Group in bits 6:4, register select in bits 3:0 |
| m_bus | input | W | M data input |
| i_bus | input | W | I data input |
| k_bus | input | W | Operand mask |
| ci | input | 1 | Carry into the lowest slice |
| li | input | 1 | Shift input into the highest bit |
| co | output | 1 | Carry, or not-zero flag, out of the highest slice |
| ro | output | 1 | Bit shifted out of the lowest slice |
| a_bus | output | W | Address register contents |
| d_bus | output | W | Accumulator contents |

## Verification
The scratch and temporary registers cannot be seen at the ports, so their contents are hard to check directly. The stimulus brings each one out with a group-1 operation that uses an all-zero mask and a clear carry. This copies the register to `a_bus` and leaves it unchanged, and it is repeated over all twelve selects after reset and again after a long random run. The full-width carry ripple and the not-zero flag of a zero result need specific operands. Directed steps build them: an all-ones accumulator plus one, and an OR of a zero register under a zero mask.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    localparam int SLICE_W = 2;
    localparam int NREG    = 12;
    localparam int SEL_AC  = 11;

    typedef enum logic [2:0] {
        G_ADDR = 3'd0,
        G_STEP = 3'd1,
        G_AND  = 3'd2,
        G_OR   = 3'd3,
        G_XNR  = 3'd4,
        G_XNM  = 3'd5,
        G_ADDI = 3'd6,
        G_SHR  = 3'd7
    } grp_e;

    typedef struct packed {
        grp_e       grp;
        logic [3:0] sel;
        logic       valid;
        logic       arith;
        logic       shift;
        logic       wr_acc;
        logic       wr_mar;
    } ctrl_t;

endpackage

// File: rtl/bsa_decode.sv
module bsa_decode
    import bsa_pkg::*;
(
    input  logic [6:0] func,
    output ctrl_t      ctl
);

    always_comb begin
        ctl        = '0;
        ctl.grp    = grp_e'(func[6:4]);
        ctl.sel    = func[3:0];
        ctl.valid  = (func[3:0] < 4'(NREG));
        unique case (ctl.grp)
            G_ADDR: begin
                ctl.arith  = 1'b1;
                ctl.wr_acc = 1'b1;
            end
            G_STEP: begin
                ctl.arith  = 1'b1;
                ctl.wr_mar = 1'b1;
            end
            G_ADDI: ctl.arith = 1'b1;
            G_SHR:  ctl.shift = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/bsa_slice.sv
module bsa_slice
    import bsa_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  ctrl_t              ctl,
    input  logic [SLICE_W-1:0] m,
    input  logic [SLICE_W-1:0] i,
    input  logic [SLICE_W-1:0] k,
    input  logic               ci,
    input  logic               li,
    output logic               co,
    output logic               ro,
    output logic [SLICE_W-1:0] mar_q,
    output logic [SLICE_W-1:0] ac_q
);

    logic [SLICE_W-1:0] regs [NREG];
    logic [3:0]         idx;
    logic [SLICE_W-1:0] rsel, opa, bsrc, opb, res;
    logic [SLICE_W:0]   sum;

    assign ac_q = regs[SEL_AC];

    always_comb begin
        idx  = ctl.valid ? ctl.sel : 4'd0;
        rsel = ctl.valid ? regs[idx] : '0;
        unique case (ctl.grp)
            G_XNM:   opa = m;
            G_ADDI:  opa = i;
            default: opa = rsel;
        endcase
        bsrc = (ctl.grp == G_STEP) ? '1 : regs[SEL_AC];
        opb  = bsrc & k;
        sum  = {1'b0, opa} + {1'b0, opb} + {{SLICE_W{1'b0}}, ci};
    end

    always_comb begin
        unique case (ctl.grp)
            G_ADDR, G_STEP, G_ADDI: res = sum[SLICE_W-1:0];
            G_AND:                  res = opa & opb;
            G_OR:                   res = opa | opb;
            G_XNR, G_XNM:           res = ~(opa ^ opb);
            G_SHR:                  res = {li, rsel[SLICE_W-1:1]};
            default:                res = '0;
        endcase
        if (!ctl.valid)     co = ci;
        else if (ctl.arith) co = sum[SLICE_W];
        else if (ctl.shift) co = ci;
        else                co = ci | (|res);
        ro = (ctl.valid && ctl.shift) ? rsel[0] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) regs[r] <= '0;
            mar_q <= '0;
        end else if (ctl.valid) begin
            regs[idx] <= res;
            if (ctl.wr_acc) regs[SEL_AC] <= res;
            if (ctl.wr_mar) mar_q <= rsel | k;
        end
    end

    // R5: address register takes register OR mask
    a_r5_mar_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.valid && ctl.grp == G_STEP) |=> (mar_q == ($past(rsel) | $past(k))));

    // R10: address register changes only in the step group
    a_r10_mar_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.valid && ctl.grp == G_STEP) |=> $stable(mar_q));

    // R4: add-register result also lands in the accumulator
    a_r4_acc_both: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.valid && ctl.grp == G_ADDR) |=> (ac_q == $past(res)));

endmodule

// File: rtl/bitslice_array.sv
module bitslice_array
    import bsa_pkg::*;
#(
    parameter  int SLICES = 8,
    localparam int W      = SLICES * SLICE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [6:0]   func,
    input  logic [W-1:0] m_bus,
    input  logic [W-1:0] i_bus,
    input  logic [W-1:0] k_bus,
    input  logic         ci,
    input  logic         li,
    output logic         co,
    output logic         ro,
    output logic [W-1:0] a_bus,
    output logic [W-1:0] d_bus
);

    ctrl_t ctl;
    logic  cy_c [SLICES+1];
    logic  sh_c [SLICES+1];

    bsa_decode dec_i (
        .func (func),
        .ctl  (ctl)
    );

    assign cy_c[0]      = ci;
    assign sh_c[SLICES] = li;

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        bsa_slice sl_i (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ctl),
            .m     (m_bus[s*SLICE_W +: SLICE_W]),
            .i     (i_bus[s*SLICE_W +: SLICE_W]),
            .k     (k_bus[s*SLICE_W +: SLICE_W]),
            .ci    (cy_c[s]),
            .li    (sh_c[s+1]),
            .co    (cy_c[s+1]),
            .ro    (sh_c[s]),
            .mar_q (a_bus[s*SLICE_W +: SLICE_W]),
            .ac_q  (d_bus[s*SLICE_W +: SLICE_W])
        );
    end

    assign co = cy_c[SLICES];
    assign ro = sh_c[0];

    // R2: out-of-range select leaves visible storage alone
    a_r2_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (func[3:0] > 4'd11) |=> ($stable(a_bus) && $stable(d_bus)));

    // R2: out-of-range select passes carry through
    a_r2_carry_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (func[3:0] > 4'd11) |-> (co == ci));

    // R9: shift output idle outside the shift group
    a_r9_ro_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (func[6:4] != 3'd7) |-> !ro);

endmodule

// File: tb/bitslice_array_tb_top.sv
module bitslice_array_tb_top;

    localparam int SL = 8;
    localparam int W  = 2 * SL;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [6:0]   func;
    logic [W-1:0] m_bus, i_bus, k_bus;
    logic         ci, li;
    logic         co, ro;
    logic [W-1:0] a_bus, d_bus;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    logic [W-1:0] mr [12];
    logic [W-1:0] mmar;

    bitslice_array #(.SLICES(SL)) dut_i (
        .clk(clk), .rst_n(rst_n), .func(func), .m_bus(m_bus), .i_bus(i_bus),
        .k_bus(k_bus), .ci(ci), .li(li), .co(co), .ro(ro),
        .a_bus(a_bus), .d_bus(d_bus)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] g, input bit valid);
        if (!valid) return "R2";
        case (g)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd5: return "R7";
            3'd6: return "R8";
            3'd7: return "R9";
            default: return "R6";
        endcase
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic step(input logic [6:0] f, input logic [W-1:0] m, input logic [W-1:0] iv,
                        input logic [W-1:0] k, input logic c, input logic l, input string tg);
        logic [2:0]   g;
        logic [3:0]   sel;
        bit           valid;
        logic [W-1:0] rv, ac, res, nmar;
        logic [W:0]   s;
        logic         eco, ero;
        string        tag;
        @(negedge clk);
        func = f; m_bus = m; i_bus = iv; k_bus = k; ci = c; li = l;
        #1;
        g = f[6:4]; sel = f[3:0]; valid = (sel < 4'd12);
        tag = (tg == "") ? tag_of(g, valid) : tg;
        rv = valid ? mr[sel] : '0;
        ac = mr[11];
        nmar = mmar; ero = 1'b0; res = '0; s = '0;
        case (g)
            3'd0: begin s = {1'b0, rv} + {1'b0, ac & k} + (W+1)'(c); res = s[W-1:0]; eco = s[W]; end
            3'd1: begin s = {1'b0, rv} + {1'b0, k} + (W+1)'(c); res = s[W-1:0]; eco = s[W]; nmar = rv | k; end
            3'd2: begin res = rv & (ac & k); eco = c | (|res); end
            3'd3: begin res = rv | (ac & k); eco = c | (|res); end
            3'd4: begin res = ~(rv ^ (ac & k)); eco = c | (|res); end
            3'd5: begin res = ~(m ^ (ac & k)); eco = c | (|res); end
            3'd6: begin s = {1'b0, iv} + {1'b0, ac & k} + (W+1)'(c); res = s[W-1:0]; eco = s[W]; end
            default: begin res = {l, rv[W-1:1]}; eco = c; ero = rv[0]; end
        endcase
        if (!valid) begin eco = c; ero = 1'b0; end
        chk(co === eco, {tag, " co"}, W'(co), W'(eco));
        chk(ro === ero, {tag, " ro"}, W'(ro), W'(ero));
        @(posedge clk);
        #1;
        if (valid) begin
            mr[sel] = res;
            if (g == 3'd0) mr[11] = res;
            if (g == 3'd1) mmar = nmar;
        end
        chk(a_bus === mmar, {tag, " R10 a_bus"}, a_bus, mmar);
        chk(d_bus === mr[11], {tag, " R10 d_bus"}, d_bus, mr[11]);
    endtask

    task automatic dump_all(input string tg);
        for (int r = 0; r < 12; r++) step({3'd1, 4'(r)}, '0, '0, '0, 1'b0, 1'b0, tg);
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4177));
        for (int r = 0; r < 12; r++) mr[r] = '0;
        mmar = '0;
        rst_n = 1'b0; func = '0; m_bus = '0; i_bus = '0; k_bus = '0; ci = 0; li = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(a_bus === '0, "R1 a_bus", a_bus, '0);
        chk(d_bus === '0, "R1 d_bus", d_bus, '0);
        rst_n = 1'b1;
        dump_all("R1");

        // directed corners
        step({3'd6, 4'd3}, '0, 16'h1234, '0, 0, 0, "R8");
        step({3'd6, 4'd11}, '0, 16'h00FF, '0, 0, 0, "R8");
        step({3'd0, 4'd3}, '0, '0, '1, 0, 0, "R4");
        step({3'd0, 4'd3}, '0, '0, '0, 1, 0, "R4");
        step({3'd2, 4'd3}, '0, '0, 16'h0F0F, 0, 0, "R3");
        step({3'd6, 4'd11}, '0, 16'hFFFF, '0, 0, 0, "R8");
        step({3'd6, 4'd5}, '0, 16'h0001, '0, 0, 0, "R8");
        step({3'd0, 4'd5}, '0, '0, '1, 0, 0, "R4");
        step({3'd1, 4'd3}, '0, '0, '1, 0, 0, "R5");
        step({3'd1, 4'd3}, '0, '0, '0, 1, 0, "R5");
        step({3'd6, 4'd7}, '0, '0, '0, 0, 0, "R8");
        step({3'd3, 4'd7}, '0, '0, '0, 0, 0, "R6");
        step({3'd3, 4'd7}, '0, '0, '0, 1, 0, "R6");
        step({3'd4, 4'd3}, '0, '0, '1, 0, 0, "R6");
        step({3'd5, 4'd11}, 16'hA5C3, '0, '0, 0, 0, "R7");
        step({3'd5, 4'd10}, 16'h3C3C, '0, '1, 0, 0, "R7");
        step({3'd7, 4'd11}, '0, '0, '0, 0, 1, "R9");
        step({3'd7, 4'd11}, '0, '0, '0, 1, 0, "R9");
        step({3'd7, 4'd10}, '0, '0, '0, 0, 1, "R9");
        for (int q = 12; q < 16; q++) step({3'(q - 12), 4'(q)}, '1, '1, '1, 1, 1, "R2");
        step({3'd7, 4'd15}, '1, '1, '1, 0, 1, "R2");
        step({3'd5, 4'd3}, 16'h5555, '0, 16'h00F0, 0, 0, "R3");
        dump_all("R5");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] kk;
            case ($urandom_range(0, 2))
                0:       kk = '0;
                1:       kk = '1;
                default: kk = W'($urandom);
            endcase
            step(7'($urandom), W'($urandom), W'($urandom), kk,
                 1'($urandom), 1'($urandom), "");
        end
        dump_all("R10");
        finish_run();
    end

endmodule